// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Collector

This block sits on a host register bus and presents four 32-bit direct registers. Two of them, a pointer and a data port, open a window onto a much larger internal register set that is organised as several channels of identical register rows. Software loads the pointer with a channel selector and an internal register address, then every access to the data port reads or writes that one internal word. The two fields of the pointer sit in opposite 16-bit halves of the word, so a half-word store can retarget the channel without touching the address, or the reverse.

The other two direct registers collect hardware events. Single-cycle event pulses latch into a pending register, software clears pending bits by writing ones, and a mask register picks which pending bits drive the level-sensitive interrupt output. Only a fixed set of event positions is implemented; the rest always read zero.

Top module: `idxwin_top`

## Requirements
- R1: The direct registers sit at word index `bus_reg` 0 (pointer, byte offset 0x00), 1 (data port, 0x04), 2 (pending, 0x08) and 3 (enable, 0x0C). The pointer reads back the channel in bits [1:0] and the internal address in bits [27:16]; every other pointer bit reads 0.
- R2: A pointer write changes only the bytes whose `bus_be` bit is set, so a write with `bus_be` = 4'b0011 changes only the channel and one with 4'b1100 changes only the internal address; without a pointer write the pointer holds its value.
- R3: A data-port write stores the byte lanes selected by `bus_be` into the internal word addressed by the pointer's current channel and address; a data-port read returns that word. Each channel has its own storage for the same address.
- R4: Internal addresses at or above the implemented depth (0x40 by default) read as zero through the data port, and writes to them change no stored word.
- R5: After reset the pointer, the pending register, the enable register and every implemented internal word are zero, and the interrupt output is low.
- R6: An event pulse on input bit i sets pending bit i in the next cycle for the implemented positions 0, 1, 2, 3, 4, 8, 9, 10, 11, 16 and 17 (mask 0x00030F1F); no pending bit sets without an event.
- R7: Writing the pending register clears each bit whose data bit is 1 and whose byte lane is enabled; bits written with 0 keep their value.
- R8: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R9: The enable register uses the pending register's bit layout, is written per byte lane, and reads 0 at the unimplemented positions.
- R10: The interrupt output is high exactly when some pending bit is set whose enable bit is also set.
- R11: A pending-register read returns the raw pending bits whatever the enable register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Direct register word index (byte offset / 4) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_reg` and current state |
| evt_in | input | EVT_W (18) | Single-cycle event pulses, one per pending position |
| irq_out | output | 1 | Interrupt request level |

## Verification
The assertions assume each access lasts exactly one cycle, that an event is a pulse whose bit is meant to land in the pending register on the next edge, and that the pointer is never written in the same cycle as the data port, which the single bus makes impossible anyway. They also take the read data as meaningful only while a read is strobed. The stimulus presents one access per cycle, drops every strobe and event pulse right after the edge that consumes it, and deliberately lines up an event with a clearing write only in the dedicated collision case.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

   localparam int BUS_W   = 32;
   localparam int LANES   = BUS_W / 8;
   localparam int PTR_LSB = 16;

   typedef enum logic [1:0] {
      SLOT_PTR  = 2'd0,
      SLOT_DATA = 2'd1,
      SLOT_PEND = 2'd2,
      SLOT_ENA  = 2'd3
   } slot_e;

   function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] be);
      logic [BUS_W-1:0] m;
      for (int b = 0; b < LANES; b++) begin
         m[b*8 +: 8] = {8{be[b]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/idxwin_decode.sv
module idxwin_decode
   import idxwin_pkg::*;
(
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [1:0] bus_reg,
   output slot_e      slot,
   output logic       ptr_wr,
   output logic       data_wr,
   output logic       pend_wr,
   output logic       ena_wr
);

   logic wr_any;

   assign slot   = slot_e'(bus_reg);
   assign wr_any = bus_sel && bus_wr;

   always_comb begin
      ptr_wr  = 1'b0;
      data_wr = 1'b0;
      pend_wr = 1'b0;
      ena_wr  = 1'b0;
      if (wr_any) begin
         unique case (slot)
            SLOT_PTR:  ptr_wr  = 1'b1;
            SLOT_DATA: data_wr = 1'b1;
            SLOT_PEND: pend_wr = 1'b1;
            SLOT_ENA:  ena_wr  = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/idxwin_ptr.sv
module idxwin_ptr
   import idxwin_pkg::*;
#(
   parameter int CHAN_W  = 2,
   parameter int IADDR_W = 12
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LANES-1:0]   be,
   input  logic [BUS_W-1:0]   wdata,
   output logic [BUS_W-1:0]   ptr_word,
   output logic [CHAN_W-1:0]  chan,
   output logic [IADDR_W-1:0] iaddr
);

   localparam logic [BUS_W-1:0] CHAN_MASK  = BUS_W'((64'd1 << CHAN_W) - 64'd1);
   localparam logic [BUS_W-1:0] ADDR_MASK  = BUS_W'(((64'd1 << IADDR_W) - 64'd1) << PTR_LSB);
   localparam logic [BUS_W-1:0] FIELD_MASK = CHAN_MASK | ADDR_MASK;

   generate
      if (CHAN_W < 1 || CHAN_W > PTR_LSB) begin : g_bad_chan
         $error("idxwin_ptr: channel field must fit the low half-word");
      end
      if (IADDR_W < 1 || PTR_LSB + IADDR_W > BUS_W) begin : g_bad_addr
         $error("idxwin_ptr: address field must fit the high half-word");
      end
   endgenerate

   logic [BUS_W-1:0] ptr_q;
   logic [BUS_W-1:0] lane_d;

   genvar b;
   generate
      for (b = 0; b < LANES; b++) begin : g_lane
         always_comb begin
            if (wr_en && be[b]) begin
               lane_d[b*8 +: 8] = wdata[b*8 +: 8];
            end else begin
               lane_d[b*8 +: 8] = ptr_q[b*8 +: 8];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         ptr_q <= lane_d & FIELD_MASK;
      end
   end

   assign ptr_word = ptr_q;
   assign chan     = ptr_q[CHAN_W-1:0];
   assign iaddr    = ptr_q[PTR_LSB +: IADDR_W];

endmodule

// File: rtl/idxwin_bank.sv
module idxwin_bank
   import idxwin_pkg::*;
#(
   parameter int CHAN_W  = 2,
   parameter int IADDR_W = 12,
   parameter int DEPTH   = 64
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [LANES-1:0]   be,
   input  logic [BUS_W-1:0]   wdata,
   input  logic [CHAN_W-1:0]  chan,
   input  logic [IADDR_W-1:0] iaddr,
   output logic [BUS_W-1:0]   rdata
);

   localparam int NUM_CHAN = 1 << CHAN_W;
   localparam int ROW_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || DEPTH > (1 << IADDR_W)) begin : g_bad_depth
         $error("idxwin_bank: depth must lie between 2 and the address range");
      end
      if (NUM_CHAN * DEPTH > 4096) begin : g_bad_size
         $error("idxwin_bank: storage too large for a register window");
      end
   endgenerate

   logic             in_range;
   logic [ROW_W-1:0] row;
   logic [BUS_W-1:0] chan_rd [NUM_CHAN];

   assign in_range = (32'(iaddr) < 32'(DEPTH));
   assign row      = iaddr[ROW_W-1:0];

   genvar c;
   generate
      for (c = 0; c < NUM_CHAN; c++) begin : g_chan
         logic [BUS_W-1:0] row_q [DEPTH];
         logic             hit;

         assign hit = wr_en && in_range && (chan == CHAN_W'(c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int j = 0; j < DEPTH; j++) begin
                  row_q[j] <= '0;
               end
            end else if (hit) begin
               for (int k = 0; k < LANES; k++) begin
                  if (be[k]) begin
                     row_q[row][k*8 +: 8] <= wdata[k*8 +: 8];
                  end
               end
            end
         end

         assign chan_rd[c] = in_range ? row_q[row] : '0;
      end
   endgenerate

   assign rdata = chan_rd[chan];

endmodule

// File: rtl/idxwin_irq.sv
module idxwin_irq
   import idxwin_pkg::*;
#(
   parameter int              EVT_W    = 18,
   parameter logic [EVT_W-1:0] IRQ_MASK = 18'h30F1F
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_wr,
   input  logic             ena_wr,
   input  logic [LANES-1:0] be,
   input  logic [BUS_W-1:0] wdata,
   input  logic [EVT_W-1:0] evt_in,
   output logic [EVT_W-1:0] pend_q,
   output logic [EVT_W-1:0] ena_q,
   output logic             irq
);

   generate
      if (EVT_W < 1 || EVT_W > BUS_W) begin : g_bad_w
         $error("idxwin_irq: event width must fit one bus word");
      end
   endgenerate

   logic [BUS_W-1:0] wmask;
   logic             unused_bits;

   assign wmask       = lane_bits(be);
   assign unused_bits = ^{wdata, wmask, evt_in};

   genvar i;
   generate
      for (i = 0; i < EVT_W; i++) begin : g_bit
         if (IRQ_MASK[i]) begin : g_live
            logic clr;
            assign clr = pend_wr && wmask[i] && wdata[i];

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pend_q[i] <= 1'b0;
                  ena_q[i]  <= 1'b0;
               end else begin
                  pend_q[i] <= evt_in[i] | (pend_q[i] & ~clr);
                  if (ena_wr && wmask[i]) begin
                     ena_q[i] <= wdata[i];
                  end
               end
            end
         end else begin : g_dead
            assign pend_q[i] = 1'b0;
            assign ena_q[i]  = 1'b0;
         end
      end
   endgenerate

   assign irq = |(pend_q & ena_q);

endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
   import idxwin_pkg::*;
#(
   parameter int               CHAN_W   = 2,
   parameter int               IADDR_W  = 12,
   parameter int               DEPTH    = 64,
   parameter int               EVT_W    = 18,
   parameter logic [EVT_W-1:0] IRQ_MASK = 18'h30F1F
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [1:0]       bus_reg,
   input  logic [3:0]       bus_be,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [EVT_W-1:0] evt_in,
   output logic             irq_out
);

   slot_e              slot;
   logic               ptr_wr, data_wr, pend_wr, ena_wr;
   logic [BUS_W-1:0]   ptr_word;
   logic [CHAN_W-1:0]  chan;
   logic [IADDR_W-1:0] iaddr;
   logic [BUS_W-1:0]   bank_rd;
   logic [EVT_W-1:0]   pend_q, ena_q;

   idxwin_decode u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_reg (bus_reg),
      .slot    (slot),
      .ptr_wr  (ptr_wr),
      .data_wr (data_wr),
      .pend_wr (pend_wr),
      .ena_wr  (ena_wr)
   );

   idxwin_ptr #(.CHAN_W(CHAN_W), .IADDR_W(IADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ptr_wr),
      .be       (bus_be),
      .wdata    (bus_wdata),
      .ptr_word (ptr_word),
      .chan     (chan),
      .iaddr    (iaddr)
   );

   idxwin_bank #(.CHAN_W(CHAN_W), .IADDR_W(IADDR_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (data_wr),
      .be    (bus_be),
      .wdata (bus_wdata),
      .chan  (chan),
      .iaddr (iaddr),
      .rdata (bank_rd)
   );

   idxwin_irq #(.EVT_W(EVT_W), .IRQ_MASK(IRQ_MASK)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_wr (pend_wr),
      .ena_wr  (ena_wr),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .evt_in  (evt_in),
      .pend_q  (pend_q),
      .ena_q   (ena_q),
      .irq     (irq_out)
   );

   always_comb begin
      unique case (slot)
         SLOT_PTR:  bus_rdata = ptr_word;
         SLOT_DATA: bus_rdata = bank_rd;
         SLOT_PEND: bus_rdata = 32'(pend_q);
         SLOT_ENA:  bus_rdata = 32'(ena_q);
      endcase
   end

endmodule

// File: rtl/idxwin_chk.sv
module idxwin_chk #(
   parameter int               IADDR_W  = 12,
   parameter int               DEPTH    = 64,
   parameter int               EVT_W    = 18,
   parameter logic [EVT_W-1:0] IRQ_MASK = 18'h30F1F
)(
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [1:0]         bus_reg,
   input logic [3:0]         bus_be,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic [EVT_W-1:0]   evt_in,
   input logic               irq_out,
   input logic [EVT_W-1:0]   pend_q,
   input logic [EVT_W-1:0]   ena_q,
   input logic [31:0]        ptr_word,
   input logic [IADDR_W-1:0] iaddr
);

   logic             ptr_wr_c, pend_wr_c, ena_wr_c, data_rd_c;
   logic [31:0]      bmask;
   logic [EVT_W-1:0] clr_req;

   assign ptr_wr_c  = bus_sel && bus_wr && (bus_reg == 2'd0);
   assign pend_wr_c = bus_sel && bus_wr && (bus_reg == 2'd2);
   assign ena_wr_c  = bus_sel && bus_wr && (bus_reg == 2'd3);
   assign data_rd_c = bus_sel && !bus_wr && (bus_reg == 2'd1);
   assign bmask     = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
   assign clr_req   = pend_wr_c ? (bus_wdata[EVT_W-1:0] & bmask[EVT_W-1:0] & ~evt_in) : '0;

   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_wr_c |=> $stable(ptr_word)); // R2

   AST_FAR_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_c && (32'(iaddr) >= 32'(DEPTH))) |-> (bus_rdata == 32'h0)); // R4

   AST_EVT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_in & IRQ_MASK)) |=> ((pend_q & $past(evt_in & IRQ_MASK)) == $past(evt_in & IRQ_MASK))); // R8

   AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_in)) == '0)); // R6

   AST_W1C_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req != '0) |=> ((pend_q & $past(clr_req)) == '0)); // R7

   AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (((pend_q | ena_q) & ~IRQ_MASK) == '0)); // R9

   AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(evt_in & ena_q & IRQ_MASK)) && !ena_wr_c) |=> irq_out); // R10

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q == '0) |-> !irq_out); // R10

endmodule

bind idxwin_top idxwin_chk #(
   .IADDR_W  (IADDR_W),
   .DEPTH    (DEPTH),
   .EVT_W    (EVT_W),
   .IRQ_MASK (IRQ_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_reg   (bus_reg),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .evt_in    (evt_in),
   .irq_out   (irq_out),
   .pend_q    (pend_q),
   .ena_q     (ena_q),
   .ptr_word  (ptr_word),
   .iaddr     (iaddr)
);

// File: tb/sim_idxwin_top.sv
`timescale 1ns/1ps
module sim_idxwin_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_reg = 2'd0;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [17:0] evt_in = 18'h0;
   logic        irq_out;

   int total = 0;
   int bad   = 0;
   logic chk_now = 1'b0;
   logic done = 1'b0;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   idxwin_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_reg   (bus_reg),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_in    (evt_in),
      .irq_out   (irq_out)
   );

   // Monitor: pops the scoreboard between edges and compares.
   always @(negedge clk) begin
      if (chk_now && sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb.pop_front();
         act = (it.kind == 0) ? bus_rdata : {31'h0, irq_out};
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic idle();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = 32'h0; evt_in = 18'h0;
   endtask

   task automatic wr_reg(input logic [1:0] r, input logic [3:0] be, input logic [31:0] d,
                         input logic [17:0] ev = 18'h0);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_reg = r; bus_be = be; bus_wdata = d; evt_in = ev;
      @(posedge clk); #1;
      idle();
   endtask

   task automatic set_ptr(input logic [1:0] ch, input logic [11:0] ad);
      wr_reg(2'd0, 4'hF, {4'h0, ad, 14'h0, ch});
   endtask

   task automatic rd_reg(input logic [1:0] r, input logic [31:0] exp, input string tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_reg = r;
      sb.push_back('{kind: 0, exp: exp, tag: tag});
      chk_now = 1'b1;
      @(posedge clk); #1;
      chk_now = 1'b0;
      idle();
   endtask

   task automatic chk_irq(input logic e, input string tag);
      sb.push_back('{kind: 1, exp: {31'h0, e}, tag: tag});
      chk_now = 1'b1;
      @(posedge clk); #1;
      chk_now = 1'b0;
   endtask

   task automatic pulse(input logic [17:0] ev);
      evt_in = ev;
      @(posedge clk); #1;
      evt_in = 18'h0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R5 reset state
      rd_reg(2'd0, 32'h0, "R5 pointer after reset");
      rd_reg(2'd2, 32'h0, "R5 pending after reset");
      rd_reg(2'd3, 32'h0, "R5 enable after reset");
      rd_reg(2'd1, 32'h0, "R5 internal word after reset");
      chk_irq(1'b0, "R5 irq after reset");

      // R1 pointer layout
      wr_reg(2'd0, 4'hF, 32'hFFFF_FFFF);
      rd_reg(2'd0, 32'h0FFF_0003, "R1 pointer keeps only its fields");
      set_ptr(2'd2, 12'h015);
      rd_reg(2'd0, 32'h0015_0002, "R1 pointer layout");

      // R2 independent halves
      wr_reg(2'd0, 4'b0011, 32'hFFFF_0001);
      rd_reg(2'd0, 32'h0015_0001, "R2 low half changes channel only");
      wr_reg(2'd0, 4'b1100, 32'h0033_FFFF);
      rd_reg(2'd0, 32'h0033_0001, "R2 high half changes address only");

      // R3 indexed access
      wr_reg(2'd1, 4'hF, 32'hDEAD_BEEF);
      rd_reg(2'd1, 32'hDEAD_BEEF, "R3 data write/read");
      wr_reg(2'd1, 4'b0100, 32'h00AA_0000);
      rd_reg(2'd1, 32'hDEAA_BEEF, "R3 byte lane write");
      set_ptr(2'd2, 12'h033);
      rd_reg(2'd1, 32'h0, "R3 other channel separate");
      set_ptr(2'd3, 12'h03F);
      wr_reg(2'd1, 4'hF, 32'h1357_9BDF);
      rd_reg(2'd1, 32'h1357_9BDF, "R3 last implemented address");

      // R4 unimplemented addresses
      set_ptr(2'd0, 12'h040);
      wr_reg(2'd1, 4'hF, 32'h1234_5678);
      rd_reg(2'd1, 32'h0, "R4 address 0x40 reads zero");
      set_ptr(2'd0, 12'h000);
      rd_reg(2'd1, 32'h0, "R4 write to 0x40 did not alias");
      set_ptr(2'd1, 12'hFFF);
      rd_reg(2'd1, 32'h0, "R4 top address reads zero");
      set_ptr(2'd1, 12'h033);
      rd_reg(2'd1, 32'hDEAA_BEEF, "R3 word retained");

      // R6 / R11 pending capture
      pulse(18'h3FFFF);
      rd_reg(2'd2, 32'h0003_0F1F, "R6 implemented positions set");
      chk_irq(1'b0, "R10 irq low with enables clear");
      rd_reg(2'd2, 32'h0003_0F1F, "R11 raw pending with enables clear");

      // R9 / R10 enables
      wr_reg(2'd3, 4'hF, 32'hFFFF_FFFF);
      rd_reg(2'd3, 32'h0003_0F1F, "R9 enable layout");
      chk_irq(1'b1, "R10 irq high");

      // R7 write-one-to-clear
      wr_reg(2'd2, 4'hF, 32'h0000_0F00);
      rd_reg(2'd2, 32'h0003_001F, "R7 ones clear");
      wr_reg(2'd2, 4'hF, 32'h0);
      rd_reg(2'd2, 32'h0003_001F, "R7 zeros keep");

      // R8 event beats clear
      wr_reg(2'd2, 4'hF, 32'h0000_0008, 18'h00008);
      rd_reg(2'd2, 32'h0003_001F, "R8 event wins over clear");

      wr_reg(2'd2, 4'hF, 32'hFFFF_FFFF);
      rd_reg(2'd2, 32'h0, "R7 clear all");
      chk_irq(1'b0, "R10 irq low after clear");

      // R10 masking per bit
      wr_reg(2'd3, 4'hF, 32'h0001_0000);
      rd_reg(2'd3, 32'h0001_0000, "R9 single enable");
      pulse(18'h00010);
      chk_irq(1'b0, "R10 disabled source no irq");
      rd_reg(2'd2, 32'h0000_0010, "R11 masked bit visible");
      pulse(18'h10000);
      chk_irq(1'b1, "R10 enabled source irq");

      // R7 byte-lane qualified clear
      wr_reg(2'd2, 4'b0001, 32'hFFFF_FFFF);
      rd_reg(2'd2, 32'h0001_0000, "R7 clear limited to lane 0");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule